// File: doc/BRIEF.md
# Downstream Command Register Engine

This block is the host-side register front end for issuing one downstream command at a time to a sideband peripheral. Software first loads the two upper header words and the data word. It then writes header word 0 with its start bit set. That write launches the command. The engine presents the four assembled words to a link engine over a valid/ready request channel. It then waits for a one-cycle completion response that carries error flags and, for configuration reads, a 32-bit return value.

The start bit in header word 0 doubles as a busy flag. It clears itself when the command finishes. A configuration read writes its returned value back into header word 1. Completion and error conditions collect in a write-1-to-clear status register, which is masked by an enable register into a level interrupt. If the link engine accepts a command but never answers, a timeout with a programmable length ends the command and reports no-response.

The control state machine has three states. In ST_IDLE it waits for a launch. In ST_ISSUE it holds the request valid until the link engine accepts it. In ST_WAIT it waits for the response or the timeout. The transitions are:
- launch, from ST_IDLE to ST_ISSUE
- accept, from ST_ISSUE to ST_WAIT on req_ready
- respond, from ST_WAIT to ST_IDLE on rsp_valid
- expire, from ST_WAIT to ST_IDLE when the timeout count reaches the limit

Top module: `dncmd_regif`

## Requirements
- R1: After reset, every register reads 0, irq is low and req_valid is low.
- R2: A write to offset 0x00 with bit 3 set, while not busy, launches a command. The header 0 fields are command type [2:0], peripheral select [5:4] and data bytes [15:8], [23:16] and [31:24]. From the next cycle, req_valid is high and req_hdr0 carries the written word with bits 3 and [7:6] forced to 0. req_hdr1, req_hdr2 and req_data carry the words at 0x04, 0x08 and 0x0C. All four stay stable while req_valid is high and req_ready is low.
- R3: Bit 3 of 0x00 reads 1 from the cycle after launch until the command completes, and 0 afterwards. A write to 0x00 with bit 3 clear stores the fields without raising req_valid.
- R4: While busy, writes to 0x00, 0x04, 0x08 and 0x0C are ignored.
- R5: A response with rsp_err equal to 0 sets only status bit 28 (complete). The rsp_err bits map into status as follows: [5] to bit 6 (non-fatal), [4] to bit 5 (fatal), [3] to bit 4 (no response), [2] to bit 2 (CRC), [1] to bit 1 (wait timeout), [0] to bit 0 (bus error). Each completion also sets bit 28.
- R6: When a command of type 1 (get-configuration) receives a response, rsp_data replaces header word 1. Other command types leave header word 1 unchanged.
- R7: Writing the status register at 0x70 clears exactly the bits written as 1. If a completion sets a bit in the same cycle, the set wins.
- R8: irq equals the OR of (status AND enable at 0x6C) over all bits. It is a level and stays high until the status bits are cleared.
- R9: If no response arrives after the request is accepted, the command ends when ST_WAIT has lasted tmo_limit+1 cycles. Busy then clears and status bits 28 and 4 are set, and header word 1 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tmo_limit | input | 16 | Response timeout length in cycles |
| req_valid | output | 1 | Command presented to the link engine |
| req_ready | input | 1 | Link engine accepts the command |
| req_hdr0 | output | 32 | Header word 0 of the command |
| req_hdr1 | output | 32 | Header word 1 |
| req_hdr2 | output | 32 | Header word 2 |
| req_data | output | 32 | Data word |
| rsp_valid | input | 1 | One-cycle completion from the link engine |
| rsp_err | input | 6 | Error flags of the completion |
| rsp_data | input | 32 | Returned configuration value |
| irq | output | 1 | Level interrupt |

## Verification
A set-configuration and a get-configuration command are each run with the same header word 1 contents. The pair separates the write-back path from the plain completion path. Error responses use single-bit and multi-bit flag patterns, which reveal a wrong bit mapping. A silent link engine separates the timeout exit from the normal respond exit. Writes issued while the engine is busy, together with a start-less header 0 write, show whether the guard around launching and register updates is in place. Partial status clears and enable masks show that the interrupt level follows the masked status.

// File: rtl/dncmd_pkg.sv
package dncmd_pkg;

    localparam logic [7:0] OFS_HDR0 = 8'h00;
    localparam logic [7:0] OFS_HDR1 = 8'h04;
    localparam logic [7:0] OFS_HDR2 = 8'h08;
    localparam logic [7:0] OFS_DATA = 8'h0C;
    localparam logic [7:0] OFS_IEN  = 8'h6C;
    localparam logic [7:0] OFS_ISTS = 8'h70;

    localparam int GO_BIT = 3;

    localparam int STS_DONE     = 28;
    localparam int STS_NONFATAL = 6;
    localparam int STS_FATAL    = 5;
    localparam int STS_NORSP    = 4;
    localparam int STS_CRC      = 2;
    localparam int STS_WAITTO   = 1;
    localparam int STS_BUS      = 0;

    localparam logic [2:0] CMD_GET_CFG = 3'd1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } dn_state_e;

endpackage

// File: rtl/dncmd_fsm.sv
module dncmd_fsm
    import dncmd_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             req_valid,
    output logic             busy,
    output logic             done,
    output logic             timed_out
);

    dn_state_e        state_q, state_d;
    logic [TMO_W-1:0] cnt_q;
    logic             expire;

    assign expire = (cnt_q >= tmo_limit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch)                 state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready)              state_d = ST_WAIT;
            ST_WAIT:  if (rsp_valid || expire)    state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT && !expire)
                cnt_q <= cnt_q + 1'b1;
            else if (state_q != ST_WAIT)
                cnt_q <= '0;
        end
    end

    always_comb begin
        req_valid = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        timed_out = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_ISSUE: req_valid = 1'b1;
            ST_WAIT: begin
                done      = rsp_valid || expire;
                timed_out = !rsp_valid && expire;
            end
            default:  busy = 1'b0;
        endcase
    end

    // R2
    launch_to_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(launch));

    // R9
    tmo_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> (cnt_q <= tmo_limit));

    // R3
    done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/dncmd_status.sv
module dncmd_status
    import dncmd_pkg::*;
#(
    parameter int ERR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_we,
    input  logic             sts_we,
    input  logic [31:0]      wdata,
    input  logic             evt,
    input  logic             evt_tmo,
    input  logic [ERR_W-1:0] evt_err,
    output logic [31:0]      sts_q,
    output logic [31:0]      ien_q,
    output logic             irq
);

    localparam int ERR_POS [ERR_W] = '{STS_NONFATAL, STS_FATAL, STS_NORSP,
                                       STS_CRC, STS_WAITTO, STS_BUS};

    logic [31:0] err_map;
    logic [31:0] set_vec;
    logic [31:0] clr_vec;

    generate
        for (genvar g = 0; g < ERR_W; g++) begin : g_map
            always_comb begin
                err_map[ERR_POS[ERR_W-1-g]] = evt_err[g];
            end
        end
    endgenerate

    always_comb begin
        set_vec = '0;
        if (evt) begin
            set_vec[STS_DONE]  = 1'b1;
            set_vec[STS_NORSP] = evt_tmo;
            if (!evt_tmo)
                set_vec = set_vec | (err_map & mask_bits());
        end
        clr_vec = sts_we ? wdata : 32'd0;
    end

    function automatic logic [31:0] mask_bits();
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < ERR_W; i++) m[ERR_POS[i]] = 1'b1;
        return m;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            ien_q <= '0;
        end else begin
            sts_q <= (sts_q & ~clr_vec) | set_vec;
            if (ien_we) ien_q <= wdata;
        end
    end

    assign irq = |(sts_q & ien_q);

    // R5
    evt_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> sts_q[STS_DONE]);

    // R7
    clear_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && wdata[STS_CRC] && !evt) |=> !sts_q[STS_CRC]);

endmodule

// File: rtl/dncmd_regif.sv
module dncmd_regif
    import dncmd_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int ERR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic [TMO_W-1:0] tmo_limit,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_hdr0,
    output logic [31:0]      req_hdr1,
    output logic [31:0]      req_hdr2,
    output logic [31:0]      req_data,
    input  logic             rsp_valid,
    input  logic [ERR_W-1:0] rsp_err,
    input  logic [31:0]      rsp_data,
    output logic             irq
);

    logic [31:0] hdr0_q, hdr1_q, hdr2_q, data_q;
    logic [31:0] sts_q, ien_q;
    logic        busy, done, timed_out, launch;
    logic        cmd_wr;

    assign cmd_wr = reg_wr && !busy;
    assign launch = cmd_wr && (reg_addr == OFS_HDR0) && reg_wdata[GO_BIT];

    dncmd_fsm #(.TMO_W(TMO_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .req_ready (req_ready),
        .rsp_valid (rsp_valid),
        .tmo_limit (tmo_limit),
        .req_valid (req_valid),
        .busy      (busy),
        .done      (done),
        .timed_out (timed_out)
    );

    dncmd_status #(.ERR_W(ERR_W)) u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .ien_we  (reg_wr && reg_addr == OFS_IEN),
        .sts_we  (reg_wr && reg_addr == OFS_ISTS),
        .wdata   (reg_wdata),
        .evt     (done),
        .evt_tmo (timed_out),
        .evt_err (rsp_err),
        .sts_q   (sts_q),
        .ien_q   (ien_q),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr0_q <= '0;
            hdr1_q <= '0;
            hdr2_q <= '0;
            data_q <= '0;
        end else begin
            if (cmd_wr) begin
                unique case (reg_addr)
                    OFS_HDR0: hdr0_q <= {reg_wdata[31:8], 2'b00, reg_wdata[5:4],
                                         1'b0, reg_wdata[2:0]};
                    OFS_HDR1: hdr1_q <= reg_wdata;
                    OFS_HDR2: hdr2_q <= reg_wdata;
                    OFS_DATA: data_q <= reg_wdata;
                    default: ;
                endcase
            end
            if (done && !timed_out && hdr0_q[2:0] == CMD_GET_CFG)
                hdr1_q <= rsp_data;
        end
    end

    assign req_hdr0 = hdr0_q;
    assign req_hdr1 = hdr1_q;
    assign req_hdr2 = hdr2_q;
    assign req_data = data_q;

    always_comb begin
        unique case (reg_addr)
            OFS_HDR0: reg_rdata = hdr0_q | (32'(busy) << GO_BIT);
            OFS_HDR1: reg_rdata = hdr1_q;
            OFS_HDR2: reg_rdata = hdr2_q;
            OFS_DATA: reg_rdata = data_q;
            OFS_IEN:  reg_rdata = ien_q;
            OFS_ISTS: reg_rdata = sts_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_hdr0) &&
        $stable(req_hdr1) && $stable(req_hdr2) && $stable(req_data)));

    // R4
    busy_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(hdr0_q) && $stable(hdr1_q) &&
        $stable(hdr2_q) && $stable(data_q)));

endmodule

// File: tb/tb_dncmd_regif.sv
`timescale 1ns/1ps
module tb_dncmd_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] tmo_limit = 16'd8;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_hdr0, req_hdr1, req_hdr2, req_data;
    logic        rsp_valid = 1'b0;
    logic [5:0]  rsp_err = '0;
    logic [31:0] rsp_data = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dncmd_regif dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmo_limit(tmo_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_hdr0(req_hdr0),
        .req_hdr1(req_hdr1), .req_hdr2(req_hdr2), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, got %0d cycles expected < 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic accept_req();
        while (!req_valid) @(negedge clk);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
    endtask

    task automatic respond(input logic [5:0] e, input logic [31:0] d);
        rsp_valid = 1'b1; rsp_err = e; rsp_data = d;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 hdr0", v, 0);
        rd(8'h04, v); chk("R1 hdr1", v, 0);
        rd(8'h70, v); chk("R1 status", v, 0);
        rd(8'h6C, v); chk("R1 enable", v, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 req_valid", 32'(req_valid), 0);
    endtask

    task automatic t_store_only();
        logic [31:0] v;
        wr(8'h00, 32'h1234_56F1);
        @(negedge clk);
        chk("R3 no launch without start bit", 32'(req_valid), 0);
        rd(8'h00, v); chk("R3 stored fields", v, 32'h1234_5631);
    endtask

    task automatic t_set_cfg();
        logic [31:0] v;
        wr(8'h04, 32'hCAFE_0001);
        wr(8'h08, 32'h0000_00AB);
        wr(8'h0C, 32'h5566_7788);
        wr(8'h00, 32'h0034_12D8);
        chk("R2 req_valid after launch", 32'(req_valid), 1);
        rd(8'h00, v); chk("R3 busy reads 1", v, 32'h0034_1218);
        repeat (3) @(negedge clk);
        chk("R2 req_hdr0 held", req_hdr0, 32'h0034_1210);
        chk("R2 req_hdr1", req_hdr1, 32'hCAFE_0001);
        chk("R2 req_hdr2", req_hdr2, 32'h0000_00AB);
        chk("R2 req_data", req_data, 32'h5566_7788);
        accept_req();
        wr(8'h04, 32'hDEAD_BEEF);
        wr(8'h00, 32'h0000_000F);
        chk("R4 no relaunch while busy", 32'(req_valid), 0);
        respond(6'b0, 32'h9999_9999);
        rd(8'h00, v); chk("R3 busy cleared", v, 32'h0034_1210);
        rd(8'h04, v); chk("R6 set-config leaves hdr1 / R4 write ignored", v, 32'hCAFE_0001);
        rd(8'h70, v); chk("R5 clean completion", v, 32'h1000_0000);
        wr(8'h70, 32'hFFFF_FFFF);
    endtask

    task automatic t_get_cfg();
        logic [31:0] v;
        wr(8'h00, 32'h0000_1009);
        accept_req();
        respond(6'b0, 32'h0102_0304);
        rd(8'h04, v); chk("R6 get-config return value", v, 32'h0102_0304);
        wr(8'h70, 32'hFFFF_FFFF);
    endtask

    task automatic t_errors();
        logic [31:0] v;
        wr(8'h00, 32'h0000_000C);
        accept_req();
        respond(6'b10_0101, 32'h0);
        rd(8'h70, v); chk("R5 error flag mapping", v, 32'h1000_0045);
        wr(8'h70, 32'h0000_0041);
        rd(8'h70, v); chk("R7 partial clear", v, 32'h1000_0004);
        wr(8'h6C, 32'h0000_0004);
        chk("R8 irq on enabled bit", 32'(irq), 1);
        repeat (3) @(negedge clk);
        chk("R8 irq level held", 32'(irq), 1);
        wr(8'h6C, 32'h0000_0001);
        chk("R8 irq masked", 32'(irq), 0);
        wr(8'h6C, 32'h1000_0000);
        wr(8'h70, 32'h1000_0000);
        chk("R8 irq after clear", 32'(irq), 0);
        wr(8'h70, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0000_000F);
        accept_req();
        respond(6'b01_1010, 32'h0);
        rd(8'h70, v); chk("R5 second flag pattern", v, 32'h1000_0032);
        chk("R8 irq from done bit", 32'(irq), 1);
        wr(8'h70, 32'hFFFF_FFFF);
        wr(8'h6C, 32'h0);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        wr(8'h04, 32'h7777_0000);
        wr(8'h00, 32'h0000_0009);
        accept_req();
        repeat (5) @(negedge clk);
        rd(8'h00, v); chk("R9 still busy before limit", v, 32'h0000_0009);
        repeat (10) @(negedge clk);
        rd(8'h00, v); chk("R9 busy cleared by timeout", v, 32'h0000_0001);
        rd(8'h70, v); chk("R9 no-response and complete", v, 32'h1000_0010);
        rd(8'h04, v); chk("R9 hdr1 untouched", v, 32'h7777_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_only();
        t_set_cfg();
        t_get_cfg();
        t_errors();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule